// File: doc/BRIEF.md
# Rectangular Even-Parity Encoder and Checker

This block protects a block of ROWS x COLS data bits with a rectangular even-parity code. It has two independent halves. The encoder accepts one data row per valid/ready beat and passes it on with one even-parity bit appended on the right. Once the last data row has been accepted, the encoder sends one more row. That row holds the even parity of every data column, plus a corner bit that makes the row itself even. A block therefore carries ROWS+COLS+1 check bits, and ROWS*COLS+ROWS+COLS+1 bits in all.

The checker accepts the ROWS+1 received rows of COLS+1 bits and recomputes every row check and every column check. After the last row it reports whether an error was seen. A single flipped bit shows up as exactly one failing row and one failing column. The checker locates that bit, corrects it if it is a data bit, and presents the recovered data matrix in parallel. Patterns it cannot resolve are flagged as uncorrectable, and the data is then left as received.

Rows travel leftmost bit first. In a row vector, bit COLS is the leftmost data bit and bit 0 is the parity bit.

Top module: `matrix_parity_codec`

## Requirements
- R1: Each encoder output beat for a data row carries `{row, p}`, where p makes the COLS+1 bits hold an even number of ones.
- R2: After ROWS data rows, the encoder emits one extra row. Its upper COLS bits are the even parity of each data column, and its bit 0 makes that row even. `enc_out_sob` marks the first row of a block and `enc_out_eob` marks the extra row.
- R3: A beat transfers only when valid and ready are both high. While the extra row is pending, `enc_in_ready` is low. Under backpressure the pending row and its flags hold, and nothing is consumed.
- R4: The data rows 1100, 1011, 0111, 0101 encode to 11000, 10111, 01111, 01010, followed by 01010.
- R5: The checker flags are valid from the cycle after the final row (row ROWS) is accepted. They hold until the first row of the next block is accepted, which clears them.
- R6: A block received intact reports no error and passes its data through unchanged.
- R7: A single flipped data bit gives exactly one failing row and one failing column. The checker inverts the bit at their intersection and asserts `chk_corrected`.
- R8: A single flipped check bit (a row-parity bit, a column-parity bit or the corner bit) asserts `chk_corrected` and leaves the data unchanged.
- R9: `chk_corner_mismatch` is high when the parity column (every row's bit 0, corner included) holds an odd number of ones.
- R10: Any other non-zero pattern of failing checks asserts `chk_uncorrectable` with `chk_error`, and the data is passed through as received.
- R11: Four flips on the corners of a rectangle satisfy every check and go unreported.
- R12: After reset the encoder expects the first row of a block, `enc_out_valid` is low while no input is offered, and every checker flag is low.

`chk_data` holds data row r at bits `[r*COLS +: COLS]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Data row offered to encoder |
| enc_in_ready | output | 1 | Encoder accepts the offered row |
| enc_in_data | input | COLS | Data row, bit COLS-1 leftmost |
| enc_out_valid | output | 1 | Encoded row available |
| enc_out_ready | input | 1 | Downstream takes the encoded row |
| enc_out_data | output | COLS+1 | Encoded row, bit 0 is parity |
| enc_out_sob | output | 1 | First row of block |
| enc_out_eob | output | 1 | Column-parity row with corner bit |
| chk_in_valid | input | 1 | Received row present this cycle |
| chk_in_row | input | COLS+1 | Received row, bit 0 is parity |
| chk_done | output | 1 | A full block has been checked |
| chk_error | output | 1 | Some check failed |
| chk_corrected | output | 1 | Single error located and handled |
| chk_uncorrectable | output | 1 | Failure pattern not resolvable |
| chk_corner_mismatch | output | 1 | Parity column check failed |
| chk_data | output | ROWS*COLS | Recovered data matrix |

## Verification
The bench flips bits in each class of position: a data bit, a row-parity bit, a column-parity bit and the corner bit. A checker that repaired check bits inside the data, or that only compared row checks, would change data it should leave alone or miss the error. Two-bit patterns in one row, and patterns on a diagonal, must come out uncorrectable rather than miscorrected. A rectangle of four flips must pass unnoticed, which confirms that no check beyond the row and column sums exists. On the encoder side, the bench stalls the extra row and offers data under backpressure. A design that dropped the end-of-block row or consumed data during the stall would start the next block with the wrong row count.

// File: rtl/matrix_parity_codec.sv
module matrix_parity_codec #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enc_in_valid,
  output logic                 enc_in_ready,
  input  logic [COLS-1:0]      enc_in_data,
  output logic                 enc_out_valid,
  input  logic                 enc_out_ready,
  output logic [COLS:0]        enc_out_data,
  output logic                 enc_out_sob,
  output logic                 enc_out_eob,
  input  logic                 chk_in_valid,
  input  logic [COLS:0]        chk_in_row,
  output logic                 chk_done,
  output logic                 chk_error,
  output logic                 chk_corrected,
  output logic                 chk_uncorrectable,
  output logic                 chk_corner_mismatch,
  output logic [ROWS*COLS-1:0] chk_data
);
  localparam int CW = $clog2(ROWS + 1);
  localparam logic [CW-1:0] LAST = CW'(ROWS);

  logic [CW-1:0]   ecnt;
  logic [COLS-1:0] eacc;
  logic            etail, efire;

  assign etail         = (ecnt == LAST);
  assign enc_in_ready  = enc_out_ready && !etail;
  assign enc_out_valid = etail || enc_in_valid;
  assign enc_out_data  = etail ? {eacc, ^eacc} : {enc_in_data, ^enc_in_data};
  assign enc_out_sob   = (ecnt == '0);
  assign enc_out_eob   = etail;
  assign efire         = enc_out_valid && enc_out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecnt <= '0;
      eacc <= '0;
    end else if (efire) begin
      if (etail) begin
        ecnt <= '0;
        eacc <= '0;
      end else begin
        ecnt <= ecnt + 1'b1;
        eacc <= eacc ^ enc_in_data;
      end
    end
  end

  logic [CW-1:0]   ccnt;
  logic [ROWS:0]   rfail, rfail_n;
  logic [COLS:0]   cacc;
  logic [COLS-1:0] store [ROWS];
  logic            single, any_fail;

  always_comb begin
    rfail_n = (ccnt == '0) ? '0 : rfail;
    rfail_n[ccnt] = ^chk_in_row;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccnt     <= '0;
      rfail    <= '0;
      cacc     <= '0;
      chk_done <= 1'b0;
    end else if (chk_in_valid) begin
      rfail    <= rfail_n;
      cacc     <= (ccnt == '0) ? chk_in_row : (cacc ^ chk_in_row);
      ccnt     <= (ccnt == LAST) ? '0 : ccnt + 1'b1;
      chk_done <= (ccnt == LAST);
    end
  end

  assign single   = ($countones(rfail) == 1) && ($countones(cacc) == 1);
  assign any_fail = (|rfail) || (|cacc);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) store[r] <= '0;
      else if (chk_in_valid && ccnt == CW'(r)) store[r] <= chk_in_row[COLS:1];
    end
    assign chk_data[r*COLS +: COLS] =
      store[r] ^ ({COLS{single && rfail[r]}} & cacc[COLS:1]);
  end

  assign chk_error           = chk_done && any_fail;
  assign chk_corrected       = chk_done && single;
  assign chk_uncorrectable   = chk_done && any_fail && !single;
  assign chk_corner_mismatch = chk_done && cacc[0];
endmodule

module matrix_parity_codec_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic enc_in_ready,
  input logic enc_out_valid,
  input logic enc_out_ready,
  input logic enc_out_sob,
  input logic enc_out_eob,
  input logic chk_in_valid,
  input logic chk_done,
  input logic chk_error,
  input logic chk_corrected,
  input logic chk_uncorrectable,
  input logic chk_corner_mismatch
);
  a_r3_tail_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_out_valid && enc_out_eob) |-> !enc_in_ready);
  a_r2_eob_then_sob: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_out_valid && enc_out_ready && enc_out_eob) |=> enc_out_sob);
  a_r5_done_after_row: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_done) |-> $past(chk_in_valid));
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_done && !chk_in_valid) |=> $stable(chk_done) && $stable(chk_error));
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_corrected && chk_uncorrectable));
  a_r9_corner_is_error: assert property (@(posedge clk) disable iff (!rst_n)
    chk_corner_mismatch |-> chk_error);
  a_r7_corrected_is_error: assert property (@(posedge clk) disable iff (!rst_n)
    chk_corrected |-> chk_error);
endmodule

bind matrix_parity_codec matrix_parity_codec_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .enc_in_ready(enc_in_ready),
  .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready),
  .enc_out_sob(enc_out_sob), .enc_out_eob(enc_out_eob),
  .chk_in_valid(chk_in_valid), .chk_done(chk_done), .chk_error(chk_error),
  .chk_corrected(chk_corrected), .chk_uncorrectable(chk_uncorrectable),
  .chk_corner_mismatch(chk_corner_mismatch)
);

// File: tb/matrix_parity_codec_tb.sv
module matrix_parity_codec_tb_top;
  logic clk = 0, rst_n = 0;
  logic enc_in_valid = 0, enc_in_ready, enc_out_valid, enc_out_ready = 1;
  logic [3:0] enc_in_data = '0;
  logic [4:0] enc_out_data;
  logic enc_out_sob, enc_out_eob;
  logic chk_in_valid = 0;
  logic [4:0] chk_in_row = '0;
  logic chk_done, chk_error, chk_corrected, chk_uncorrectable, chk_corner_mismatch;
  logic [15:0] chk_data;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  matrix_parity_codec #(.ROWS(4), .COLS(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_in_data(enc_in_data),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready), .enc_out_data(enc_out_data),
    .enc_out_sob(enc_out_sob), .enc_out_eob(enc_out_eob),
    .chk_in_valid(chk_in_valid), .chk_in_row(chk_in_row),
    .chk_done(chk_done), .chk_error(chk_error), .chk_corrected(chk_corrected),
    .chk_uncorrectable(chk_uncorrectable), .chk_corner_mismatch(chk_corner_mismatch),
    .chk_data(chk_data));

  // {data (row0 in [15:12]), flip mask (row r at [24-5r -: 5]), class: 0 clean, 1 corrected, 2 uncorrectable}
  localparam logic [42:0] VEC [10] = '{
    {16'hCB75, 25'h0000000, 2'd0},
    {16'hCB75, 25'h0080000, 2'd1},
    {16'h0000, 25'h0000000, 2'd0},
    {16'hFFFF, 25'h0000001, 2'd1},
    {16'hA5C3, 25'h0000400, 2'd1},
    {16'h1234, 25'h0000010, 2'd1},
    {16'h1234, 25'h1800000, 2'd2},
    {16'hBEEF, 25'h1040000, 2'd2},
    {16'h5A5A, 25'h18C0000, 2'd0},
    {16'h8001, 25'h0004000, 2'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [24:0] ref_enc(input logic [15:0] d);
    logic [3:0] col = '0;
    logic [24:0] o = '0;
    for (int r = 0; r < 4; r++) begin
      o[24-5*r -: 5] = {d[15-4*r -: 4], ^d[15-4*r -: 4]};
      col ^= d[15-4*r -: 4];
    end
    o[4:0] = {col, ^col};
    return o;
  endfunction

  task automatic enc_block(input logic [15:0] d, output logic [24:0] got);
    got = '0;
    for (int r = 0; r < 5; r++) begin
      @(negedge clk);
      enc_in_valid = (r < 4);
      enc_in_data  = (r < 4) ? d[15-4*r -: 4] : 4'h0;
      #1;
      check("R2 sob", enc_out_sob, r == 0);
      check("R2 eob", enc_out_eob, r == 4);
      check("R3 valid", enc_out_valid, 1);
      if (r == 4) check("R3 tail ready", enc_in_ready, 0);
      got[24-5*r -: 5] = enc_out_data;
    end
    @(negedge clk);
    enc_in_valid = 0;
  endtask

  task automatic chk_block(input logic [24:0] rx);
    for (int r = 0; r < 5; r++) begin
      @(negedge clk);
      chk_in_valid = 1;
      chk_in_row = rx[24-5*r -: 5];
      if (r == 1) check("R5 cleared on next block", chk_done, 0);
    end
    @(negedge clk);
    chk_in_valid = 0;
    #1;
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [24:0] enc, rx;
    logic [15:0] d, exp_d, act_d;
    logic [1:0]  cls;
    logic        corner;
    repeat (3) @(negedge clk);
    #1;
    check("R12 valid", enc_out_valid, 0);
    check("R12 ready", enc_in_ready, 1);
    check("R12 sob", enc_out_sob, 1);
    check("R12 done", chk_done, 0);
    check("R12 flags", {chk_error, chk_corrected, chk_uncorrectable, chk_corner_mismatch}, 0);
    @(negedge clk);
    rst_n = 1;

    enc_block(16'hCB75, enc);
    check("R4 example", enc, 25'b11000_10111_01111_01010_01010);

    for (int v = 0; v < 10; v++) begin
      d = VEC[v][42:27];
      cls = VEC[v][1:0];
      enc_block(d, enc);
      check("R1/R2 encode", enc, ref_enc(d));
      rx = enc ^ VEC[v][26:2];
      chk_block(rx);
      corner = 0;
      for (int r = 0; r < 5; r++) corner ^= rx[20-5*r];
      exp_d = '0;
      for (int r = 0; r < 4; r++) exp_d[15-4*r -: 4] = rx[24-5*r -: 4];
      if (cls == 1) exp_d = d;
      for (int r = 0; r < 4; r++) act_d[15-4*r -: 4] = chk_data[4*r +: 4];
      check("R5 done", chk_done, 1);
      check(cls == 0 ? "R6/R11 error" : "R7/R8/R10 error", chk_error, cls != 0);
      check("R7/R8 corrected", chk_corrected, cls == 1);
      check("R10 uncorrectable", chk_uncorrectable, cls == 2);
      check("R9 corner", chk_corner_mismatch, corner);
      check(cls == 1 ? "R7/R8 data" : "R6/R10/R11 data", act_d, exp_d);
    end

    repeat (3) @(negedge clk);
    #1;
    check("R5 held idle", chk_done, 1);

    @(negedge clk);
    enc_out_ready = 0;
    enc_in_valid = 1;
    enc_in_data = 4'hF;
    #1;
    check("R3 no ready under stall", enc_in_ready, 0);
    check("R1 stalled row", enc_out_data, 5'b11110);
    @(negedge clk);
    #1;
    check("R3 nothing consumed", enc_out_sob, 1);
    enc_out_ready = 1;
    enc_in_valid = 0;
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      enc_in_valid = 1;
      enc_in_data = 4'(r + 1);
    end
    @(negedge clk);
    enc_in_valid = 0;
    enc_out_ready = 0;
    #1;
    check("R2 tail pending", enc_out_eob, 1);
    // columns: 0001^0010^0011^0100 = 0100 -> row 01001
    check("R2 tail row", enc_out_data, 5'b01001);
    @(negedge clk);
    #1;
    check("R3 tail held", {enc_out_valid, enc_out_eob}, 2'b11);
    check("R3 tail data held", enc_out_data, 5'b01001);
    enc_out_ready = 1;
    @(negedge clk);
    #1;
    check("R3 tail consumed", enc_out_valid, 0);
    check("R2 new block", enc_out_sob, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule